// File: doc/BRIEF.md
# Ethernet transmit frame assembler

This block builds an outgoing Ethernet frame out of 32-bit host data-register writes and hands it to a byte-serial transmitter. When no frame is in progress, the first write is a header. Its low half-word gives the payload length, which does not count the 14-byte MAC header. Its upper two bytes are already frame data. Each write after that adds four more frame bytes. The block counts the bytes it has received against an expected total. When the count reaches that total, the frame is complete. The block then drops the trailing CRC slot if the host supplied one, extends short frames with zeros if asked, and streams the frame out.

The transmit side is a valid/ready byte stream with a marker on the final byte. While a frame waits for transmit enable, or is being streamed, the write side signals that it is not ready. The block raises two one-cycle flags for an external interrupt register: one when a frame has been sent, and one when a header carries a length that is too large. Acknowledging that error returns the assembler to its idle state.

Top module: `eth_tx_assembler`

## Requirements
- R1: After reset the block is idle: `wr_ready`=1, `tx_valid`=0, `tx_empty_pulse`=0 and `tx_err_pulse`=0.
- R2: A write accepted while idle is a header. `wr_data[15:0]` is the payload length. `wr_data[23:16]` becomes frame byte 0 and `wr_data[31:24]` becomes frame byte 1.
- R3: A header length above 2032 discards the frame. `tx_err_pulse` is 1 in the cycle after that write, and the next write is again a header. A length of exactly 2032 is accepted.
- R4: Each accepted write after the header appends four frame bytes, `wr_data[7:0]` first and `wr_data[31:24]` last.
- R5: The frame is complete once the received byte count (2 plus 4 per data word) reaches or passes the length plus 14, or the length plus 18 when `auto_crc`=0. The frame then sent has length plus 14 bytes, so with `auto_crc`=0 the four CRC bytes are dropped. `auto_crc` is sampled at the header write.
- R6: With `pad_en`=1 (sampled at the header write), a frame shorter than 60 bytes is sent as 60 bytes, and bytes beyond the supplied data are 0x00.
- R7: The output is a valid/ready byte stream. `tx_last` is 1 on exactly the final byte. `tx_data` and `tx_last` hold steady while `tx_valid`=1 and `tx_ready`=0.
- R8: While `tx_en`=0, `tx_valid` stays 0 and a completed frame is kept. Streaming starts once `tx_en`=1.
- R9: From frame completion until its last byte is taken, `wr_ready`=0, and writes have no effect on the frame.
- R10: `tx_empty_pulse` is 1 in the cycle after the final byte handshake, and the block is idle again.
- R11: `err_ack`=1 forces the idle state from any state in the next cycle. It takes priority over a write in the same cycle, which is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host data-register write strobe |
| wr_data | input | 32 | Host write data |
| wr_ready | output | 1 | Write is accepted this cycle |
| auto_crc | input | 1 | MAC appends the CRC, so the host does not supply it |
| pad_en | input | 1 | Zero-pad short frames to 60 bytes |
| tx_en | input | 1 | Transmit enable |
| err_ack | input | 1 | Acknowledge of the transmit-error interrupt |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream takes the byte |
| tx_empty_pulse | output | 1 | One-cycle flag: frame sent |
| tx_err_pulse | output | 1 | One-cycle flag: oversize header rejected |

## Verification
An error acknowledge can arrive in the same cycle as a data write. The write may be a fresh header or a word in the middle of a frame. The bench drives both in one cycle, in each of those two situations. The outcome is judged by the frame that follows. It must come out byte-exact with its own length, which shows the colliding word was neither taken as a header nor stored as data. Output backpressure is also applied while the last byte is pending, so that the empty flag and the stream stall are tested together.

// File: rtl/eth_txa_pkg.sv
// Shared types for the transmit frame assembler.
package eth_txa_pkg;
    // Assembler phase: no frame, collecting words, frame ready/streaming
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_SEND = 2'd2
    } txa_state_e;
endpackage

// File: rtl/txa_len_calc.sv
// Length arithmetic for one header word.
// Assumes: hdr_len is the payload length without the 14-byte MAC header.
// Outputs are meaningful only when too_long is 0.
module txa_len_calc #(
    parameter int LEN_W       = 16,
    parameter int CNT_W       = 13,
    parameter int MAX_PAYLOAD = 2032,
    parameter int HDR_BYTES   = 14,
    parameter int CRC_BYTES   = 4,
    parameter int MIN_FRAME   = 60
) (
    input  logic [LEN_W-1:0] hdr_len,
    input  logic             auto_crc,
    input  logic             pad_en,
    output logic             too_long,
    output logic [CNT_W-1:0] expect_cnt,
    output logic [CNT_W-1:0] data_len,
    output logic [CNT_W-1:0] send_len
);
    // Decode the byte totals implied by the header and control bits
    always_comb begin
        too_long   = hdr_len > LEN_W'(MAX_PAYLOAD);
        data_len   = CNT_W'(hdr_len) + CNT_W'(HDR_BYTES);
        expect_cnt = auto_crc ? data_len : data_len + CNT_W'(CRC_BYTES);
        send_len   = (pad_en && (data_len < CNT_W'(MIN_FRAME))) ?
                     CNT_W'(MIN_FRAME) : data_len;
    end
endmodule

// File: rtl/txa_frame_buf.sv
// Frame byte store in four byte-wide banks, one per address lane.
// The header puts bytes 0 and 1 into banks 0 and 1.
// Each later word lands at addresses count..count+3, with count = 2 mod 4.
// Each bank therefore takes exactly one byte per write.
// Bytes beyond BUF_BYTES are dropped. Read is asynchronous.
module txa_frame_buf #(
    parameter int BUF_BYTES = 2048,
    parameter int CNT_W     = 13,
    parameter int ADDR_W    = 11
) (
    input  logic              clk,
    input  logic              hdr_we,
    input  logic              word_we,
    input  logic [CNT_W-1:0]  wr_count,
    input  logic [31:0]       wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte
);
    localparam int ROWS  = BUF_BYTES / 4;
    localparam int ROW_W = ADDR_W - 2;

    logic [7:0] lane_rd [4];

    for (genvar b = 0; b < 4; b++) begin : g_bank
        localparam int LANE = (b + 2) % 4;
        logic [7:0]       mem [ROWS];
        logic [CNT_W-1:0] row_full;

        // Row this bank's byte of the current word falls into
        always_comb row_full = (wr_count + CNT_W'(LANE)) >> 2;

        // Store the header byte or the word byte for this lane
        always_ff @(posedge clk) begin
            if (hdr_we && (b < 2)) begin
                mem[0] <= wdata[8*(b+2) +: 8];
            end else if (word_we && (row_full < CNT_W'(ROWS))) begin
                mem[row_full[ROW_W-1:0]] <= wdata[8*LANE +: 8];
            end
        end

        // Asynchronous read of the addressed row
        always_comb lane_rd[b] = mem[rd_addr[ADDR_W-1:2]];
    end

    // Select the lane of the read address
    always_comb rd_byte = lane_rd[rd_addr[1:0]];
endmodule

// File: rtl/txa_streamer.sv
// Byte streamer for a completed frame.
// Presents bytes 0..send_len-1 on a valid/ready interface.
// Bytes at or past data_len come out as zero (padding).
// Assumes send_len >= 1 while active.
module txa_streamer #(
    parameter int CNT_W  = 13,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              tx_en,
    input  logic [CNT_W-1:0]  send_len,
    input  logic [CNT_W-1:0]  data_len,
    input  logic [7:0]        buf_byte,
    input  logic              tx_ready,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              tx_last,
    output logic              done
);
    logic [CNT_W-1:0] idx;

    // Byte index: held at zero until a frame is active, advanced per handshake
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            idx <= '0;
        end else if (tx_valid && tx_ready) begin
            idx <= idx + CNT_W'(1);
        end
    end

    // Output byte, framing marker and completion strobe
    always_comb begin
        rd_addr  = idx[ADDR_W-1:0];
        tx_valid = active && tx_en;
        tx_data  = (idx < data_len) ? buf_byte : 8'h00;
        tx_last  = (idx == send_len - CNT_W'(1));
        done     = tx_valid && tx_ready && tx_last;
    end
endmodule

// File: rtl/eth_tx_assembler.sv
// Ethernet transmit frame assembler (top).
// Collects a frame from 32-bit writes: a header word, then data words.
// Checks the length, drops the CRC slot when auto_crc is off, pads short
// frames when asked, then streams the bytes out.
// Assumes: err_ack comes from the interrupt-register write path. The
// interrupt flags are one-cycle pulses that are latched outside.
module eth_tx_assembler #(
    parameter int BUF_BYTES   = 2048,
    parameter int LEN_W       = 16,
    parameter int MAX_PAYLOAD = 2032,
    parameter int HDR_BYTES   = 14,
    parameter int CRC_BYTES   = 4,
    parameter int MIN_FRAME   = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic        wr_ready,
    input  logic        auto_crc,
    input  logic        pad_en,
    input  logic        tx_en,
    input  logic        err_ack,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        tx_empty_pulse,
    output logic        tx_err_pulse
);
    import eth_txa_pkg::*;

    localparam int ADDR_W = $clog2(BUF_BYTES);
    localparam int CNT_W  = ADDR_W + 2;

    txa_state_e       state;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] expect_q, data_len_q, send_len_q;
    logic             too_long;
    logic [CNT_W-1:0] expect_d, data_len_d, send_len_d;
    logic             acc, hdr_we, word_we, done;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]       buf_byte;

    txa_len_calc #(
        .LEN_W(LEN_W), .CNT_W(CNT_W), .MAX_PAYLOAD(MAX_PAYLOAD),
        .HDR_BYTES(HDR_BYTES), .CRC_BYTES(CRC_BYTES), .MIN_FRAME(MIN_FRAME)
    ) u_len (
        .hdr_len   (wr_data[LEN_W-1:0]),
        .auto_crc  (auto_crc),
        .pad_en    (pad_en),
        .too_long  (too_long),
        .expect_cnt(expect_d),
        .data_len  (data_len_d),
        .send_len  (send_len_d)
    );

    // Write acceptance and buffer write strobes
    always_comb begin
        wr_ready = (state != ST_SEND);
        acc      = wr_en && wr_ready && !err_ack;
        hdr_we   = acc && (state == ST_IDLE) && !too_long;
        word_we  = acc && (state == ST_FILL);
    end

    txa_frame_buf #(
        .BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
    ) u_buf (
        .clk     (clk),
        .hdr_we  (hdr_we),
        .word_we (word_we),
        .wr_count(count),
        .wdata   (wr_data),
        .rd_addr (rd_addr),
        .rd_byte (buf_byte)
    );

    txa_streamer #(
        .CNT_W(CNT_W), .ADDR_W(ADDR_W)
    ) u_str (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state == ST_SEND),
        .tx_en   (tx_en),
        .send_len(send_len_q),
        .data_len(data_len_q),
        .buf_byte(buf_byte),
        .tx_ready(tx_ready),
        .rd_addr (rd_addr),
        .tx_data (tx_data),
        .tx_valid(tx_valid),
        .tx_last (tx_last),
        .done    (done)
    );

    // Frame sequencing, byte accounting and interrupt flag pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= ST_IDLE;
            count          <= '0;
            expect_q       <= '0;
            data_len_q     <= '0;
            send_len_q     <= '0;
            tx_empty_pulse <= 1'b0;
            tx_err_pulse   <= 1'b0;
        end else begin
            tx_empty_pulse <= 1'b0;
            tx_err_pulse   <= 1'b0;
            if (err_ack) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (acc) begin
                            if (too_long) begin
                                tx_err_pulse <= 1'b1;
                            end else begin
                                state      <= ST_FILL;
                                count      <= CNT_W'(2);
                                expect_q   <= expect_d;
                                data_len_q <= data_len_d;
                                send_len_q <= send_len_d;
                            end
                        end
                    end
                    ST_FILL: begin
                        if (acc) begin
                            count <= count + CNT_W'(4);
                            if ((count + CNT_W'(4)) >= expect_q) begin
                                state <= ST_SEND;
                            end
                        end
                    end
                    ST_SEND: begin
                        if (done) begin
                            state          <= ST_IDLE;
                            tx_empty_pulse <= 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/txa_chk.sv
// Protocol checker for eth_tx_assembler, attached with bind.
// Observes only the top-level ports.
module txa_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_ready,
    input logic       err_ack,
    input logic       tx_en,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_last,
    input logic       tx_ready,
    input logic       tx_empty_pulse,
    input logic       tx_err_pulse
);
    // R8
    hold_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !tx_valid);

    // R9
    no_write_while_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !wr_ready);

    // R7
    stream_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !err_ack) |=> ($stable(tx_data) && $stable(tx_last)));

    // R11
    ack_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_ack |=> (wr_ready && !tx_valid));

    // R10
    empty_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_pulse |-> $past(tx_valid && tx_ready && tx_last && !err_ack));

    // R3
    err_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err_pulse |-> $past(wr_en && wr_ready && !err_ack));

    // R3
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_err_pulse && tx_empty_pulse));
endmodule

bind eth_tx_assembler txa_chk u_chk (.*);

// File: tb/sim_eth_tx_assembler.sv
`timescale 1ns/1ps
module sim_eth_tx_assembler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        auto_crc = 1'b1;
    logic        pad_en = 1'b0;
    logic        tx_en = 1'b1;
    logic        err_ack = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_last;
    logic        tx_ready = 1'b0;
    logic        tx_empty_pulse;
    logic        tx_err_pulse;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    eth_tx_assembler u0 (.*);

    // Vector fields: payload length, auto_crc, pad_en, backpressure, bytes sent
    localparam logic [47:0] VEC [10] = '{
        {16'd46,   4'd1, 4'd0, 8'd0, 16'd60},
        {16'd46,   4'd0, 4'd0, 8'd1, 16'd60},
        {16'd10,   4'd1, 4'd1, 8'd0, 16'd60},
        {16'd10,   4'd1, 4'd0, 8'd1, 16'd24},
        {16'd10,   4'd0, 4'd1, 8'd1, 16'd60},
        {16'd100,  4'd0, 4'd0, 8'd0, 16'd114},
        {16'd45,   4'd1, 4'd1, 8'd0, 16'd60},
        {16'd0,    4'd1, 4'd0, 8'd1, 16'd14},
        {16'd1,    4'd0, 4'd0, 8'd0, 16'd15},
        {16'd2032, 4'd1, 4'd0, 8'd0, 16'd2046}
    };

    function automatic logic [7:0] fb(input int k, input int s);
        return 8'((k * 5 + s * 11 + 3) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic send_frame(input int len, input int seed, input bit crc, input bit pad);
        int expc;
        int nw;
        auto_crc = crc;
        pad_en = pad;
        wr({fb(1, seed), fb(0, seed), 16'(len)});
        expc = len + 14 + (crc ? 0 : 4);
        nw = (expc - 2 + 3) / 4;
        for (int w = 0; w < nw; w++)
            wr({fb(2+4*w+3, seed), fb(2+4*w+2, seed), fb(2+4*w+1, seed), fb(2+4*w, seed)});
    endtask

    task automatic collect(input int exp_len, input int dlen, input int seed, input bit bp,
                           input string tag);
        int n = 0;
        int bad = 0;
        int last_pos = -1;
        int guard = 0;
        bit saw_last = 0;
        while (!saw_last && guard < 6000) begin
            @(negedge clk);
            guard++;
            tx_ready = bp ? (guard % 3 != 0) : 1'b1;
            if (tx_valid && tx_ready) begin
                if (tx_data !== ((n < dlen) ? fb(n, seed) : 8'h00)) bad++;
                if (tx_last) begin
                    saw_last = 1;
                    last_pos = n;
                end
                n++;
            end
        end
        @(negedge clk);
        tx_ready = 1'b0;
        chk(n == exp_len, {"R5/R6 length ", tag}, n, exp_len);
        chk(bad == 0, {"R2/R4/R6 bytes ", tag}, bad, 0);
        chk(last_pos == exp_len - 1, {"R7 last marker ", tag}, last_pos, exp_len - 1);
        chk(tx_empty_pulse === 1'b1, {"R10 empty flag ", tag}, int'(tx_empty_pulse), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(wr_ready === 1'b1, "R1 wr_ready", int'(wr_ready), 1);
        chk(tx_valid === 1'b0, "R1 tx_valid", int'(tx_valid), 0);
        chk(tx_empty_pulse === 1'b0 && tx_err_pulse === 1'b0, "R1 flags",
            int'({tx_empty_pulse, tx_err_pulse}), 0);

        // Table walk: R2 R4 R5 R6 R7 R10
        for (int i = 0; i < 10; i++) begin
            send_frame(int'(VEC[i][47:32]), i + 1, VEC[i][28], VEC[i][24]);
            collect(int'(VEC[i][15:0]), int'(VEC[i][47:32]) + 14, i + 1, VEC[i][16],
                    $sformatf("vec%0d", i));
        end

        // R3 oversize header discarded, the next write is a header again
        auto_crc = 1'b1;
        pad_en = 1'b0;
        wr({8'hAA, 8'hBB, 16'd2033});
        @(negedge clk);
        chk(tx_err_pulse === 1'b1, "R3 error flag", int'(tx_err_pulse), 1);
        send_frame(12, 20, 1'b1, 1'b0);
        collect(26, 26, 20, 1'b0, "R3 after discard");

        // R8 hold while disabled; R9 write ignored while frame pending
        tx_en = 1'b0;
        send_frame(20, 21, 1'b1, 1'b0);
        tx_ready = 1'b1;
        repeat (8) begin
            @(negedge clk);
            chk(tx_valid === 1'b0, "R8 held while disabled", int'(tx_valid), 0);
        end
        chk(wr_ready === 1'b0, "R9 wr_ready low", int'(wr_ready), 0);
        wr(32'hDEADBEEF);
        tx_en = 1'b1;
        collect(34, 34, 21, 1'b1, "R8/R9 held frame");

        // R11 err_ack in the middle of a frame
        send_frame_partial: begin
            wr({fb(1, 22), fb(0, 22), 16'd40});
            wr(32'h11223344);
            wr(32'h55667788);
            @(negedge clk);
            err_ack = 1'b1;
            @(posedge clk);
            #1 err_ack = 1'b0;
            @(negedge clk);
            chk(wr_ready === 1'b1 && tx_valid === 1'b0, "R11 idle after ack",
                int'({wr_ready, tx_valid}), 2);
        end
        send_frame(20, 23, 1'b1, 1'b0);
        collect(34, 34, 23, 1'b0, "R11 after mid-frame ack");

        // R11 err_ack colliding with a header write: the write is dropped
        @(negedge clk);
        wr_en = 1'b1;
        err_ack = 1'b1;
        wr_data = {8'h01, 8'h02, 16'd30};
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        err_ack = 1'b0;
        send_frame(16, 24, 1'b1, 1'b0);
        collect(30, 30, 24, 1'b0, "R11 ack with header");

        // R11 err_ack colliding with a data word mid-frame
        wr({fb(1, 25), fb(0, 25), 16'd10});
        @(negedge clk);
        wr_en = 1'b1;
        err_ack = 1'b1;
        wr_data = 32'h0000FFFF;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        err_ack = 1'b0;
        send_frame(8, 25, 1'b1, 1'b0);
        collect(22, 22, 25, 1'b0, "R11 ack with data");

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule